// File: doc/BRIEF.md
# Pipelined Counter-Machine Processor

This block is a very small processor built around a counter machine. It keeps sixteen 4-bit registers and runs programs made of 8-bit words from an internal program store. Every instruction names exactly one register. That register is read through one shared path, adjusted and written back in the same cycle. The available operations are increment, decrement, clear, no-op, jump-if-nonzero and always-jump.

The machine has two pipeline stages. A fetch stage reads the next program word while an execute stage decodes, computes and writes back the current one. Jumps take two words: the opcode word, then a word holding the target address. The jump decision is kept in a flag for one cycle. The word after the address word is always executed, as a delay slot, whether or not the jump is taken.

The program store is filled through a write port, normally while reset is held. A debug port shows the program counter and the contents of any one register selected from outside.

Top module: `ctr_machine_core`

## Requirements
- R1: While `rst` is high, the program counter reads 0, every register reads 0, and the first word executed after reset release is the word at address 0.
- R2: Bits [7:4] of an instruction word are the control bits writeback, jump, zero and decrement (bit 7 to bit 4). Bits [3:0] select the register. Word 8x (1000) increments register x.
- R3: Word 9x (1001) decrements register x modulo 16, so 0 becomes 15.
- R4: Increment wraps modulo 16, so 15 becomes 0.
- R5: Word Ax (1010) writes 0 to register x.
- R6: Word 0x (0000) changes no register, and no instruction changes any register other than the one it selects.
- R7: Unless a taken jump loads it, the program counter advances by one every cycle.
- R8: Word 4x (0100) jumps when register x is nonzero. The target is the word stored directly after the jump, and the counter is loaded with it two cycles after the jump word executes.
- R9: Word 7x (0111) always jumps, even when register x is 0.
- R10: The address word after a jump is never executed as an instruction, whether or not the jump is taken.
- R11: The word that follows a jump's address word always executes (delay slot), for a taken jump and for a jump that is not taken.
- R12: `dbg_pc` shows the program counter. `dbg_val` shows register `dbg_sel` one clock after the selection.
- R13: A write on the program-load port stores `prog_data` at `prog_addr`, and that word is what later executes from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 8 | Program word to store |
| dbg_sel | input | 4 | Register shown on `dbg_val` |
| dbg_pc | output | 8 | Current program counter |
| dbg_val | output | 4 | Registered value of register `dbg_sel` |

## Verification
The hardest case to reach from the ports is the address word that follows a jump. It must be ignored even when its bit pattern is a writeback instruction, and the delay slot after it must run on both the taken and the not-taken path. The stimulus places a word that would increment a spare register in the address position of a jump that is not taken. It then puts a counted loop where a delay-slot increment runs on both paths. Each register that could be touched is read back through the debug port. The exact cycle of the counter load is checked by following `dbg_pc` edge by edge after reset release.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int WORD_W = 8;
  localparam int IDX_W  = 4;

  typedef struct packed {
    logic wb;
    logic jmp;
    logic zro;
    logic dec;
  } ctl_t;
endpackage

// File: rtl/cm_fetch.sv
module cm_fetch #(
  parameter int PC_W   = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [WORD_W-1:0] prog_data,
  input  logic              load_en,
  input  logic [PC_W-1:0]   load_addr,
  output logic [PC_W-1:0]   pc,
  output logic [WORD_W-1:0] word
);
  localparam int DEPTH = 2 ** PC_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (prog_we) store[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else     word <= store[pc];
  end

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (load_en) pc <= load_addr;
    else              pc <= pc + PC_W'(1);
  end

  a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> pc == $past(pc) + PC_W'(1));

  a_r8_pc_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> pc == $past(load_addr));
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic                    we,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DW-1:0]           dbg_val
);
  logic [DW-1:0] regs [NREG];

  assign rdata = regs[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    dbg_val <= regs[dbg_sel];
  end
endmodule

// File: rtl/cm_alu.sv
module cm_alu #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] val,
  input  logic          dec,
  input  logic          zro,
  output logic [DW-1:0] res
);
  logic [DW-1:0] pre, sum;

  always_comb begin
    pre = dec ? ~val : val;
    sum = pre + DW'(1);
    res = zro ? '0 : (dec ? ~sum : sum);
  end

  always_comb begin
    if (!zro && dec) begin
      a_r3_dec_inverse: assert (DW'(res + DW'(1)) == val);
    end
  end
endmodule

// File: rtl/ctr_machine_core.sv
module ctr_machine_core #(
  parameter int PC_W = 8,
  parameter int NREG = 16,
  parameter int DW   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prog_we,
  input  logic [PC_W-1:0]         prog_addr,
  input  logic [cm_pkg::WORD_W-1:0] prog_data,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [PC_W-1:0]         dbg_pc,
  output logic [DW-1:0]           dbg_val
);
  import cm_pkg::*;
  localparam int RI_W = $clog2(NREG);

  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] word;
  ctl_t              ctl;
  logic [RI_W-1:0]   idx;
  logic [DW-1:0]     rdata, wdata;
  logic              slot_q, take_q;
  logic              live, rf_we, is_jump, taken;

  assign ctl     = ctl_t'(word[WORD_W-1:WORD_W-4]);
  assign idx     = word[RI_W-1:0];
  assign live    = !slot_q;
  assign rf_we   = live && ctl.wb;
  assign is_jump = live && ctl.jmp;
  assign taken   = (ctl.zro && ctl.dec) || (rdata != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      slot_q <= is_jump;
      take_q <= is_jump && taken;
    end
  end

  cm_fetch #(.PC_W(PC_W), .WORD_W(WORD_W)) u_fetch (
    .clk(clk), .rst(rst),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .load_en(take_q), .load_addr(word[PC_W-1:0]),
    .pc(pc), .word(word)
  );

  cm_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst), .idx(idx), .we(rf_we), .wdata(wdata),
    .rdata(rdata), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  cm_alu #(.DW(DW)) u_alu (
    .val(rdata), .dec(ctl.dec), .zro(ctl.zro), .res(wdata)
  );

  assign dbg_pc = pc;

  a_r10_take_needs_slot: assert property (@(posedge clk) disable iff (rst)
    take_q |-> slot_q);

  a_r10_slot_once: assert property (@(posedge clk) disable iff (rst)
    slot_q |=> !slot_q);
endmodule

// File: tb/ctr_machine_core_bench.sv
module ctr_machine_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_we = 1'b0;
  logic [7:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic [3:0] dbg_sel = '0;
  logic [7:0] dbg_pc;
  logic [3:0] dbg_val;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ctr_machine_core u_ctr_machine_core (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dbg_sel(dbg_sel), .dbg_pc(dbg_pc), .dbg_val(dbg_val)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input int d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 8'(a); prog_data = 8'(d);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic read_reg(input int r, output int v);
    @(negedge clk); dbg_sel = 4'(r);
    @(negedge clk); v = int'(dbg_val);
  endtask

  task automatic expect_reg(input int r, input int exp, input string tag);
    int v;
    read_reg(r, v);
    check(v == exp, tag, v, exp);
  endtask

  // R2 R3 R4 R5 R6 R13: arithmetic, wrap, clear, no-op
  task automatic t_arith();
    hold_reset();
    put(0, 8'h81); put(1, 8'h81); put(2, 8'h81); put(3, 8'h92);
    put(4, 8'h93); put(5, 8'h83); put(6, 8'h84); put(7, 8'h84);
    put(8, 8'hA4); put(9, 8'h85); put(10, 8'h06);
    put(11, 8'h7F); put(12, 8'h0B); put(13, 8'h00);
    release_reset();
    repeat (40) @(negedge clk);
    expect_reg(1, 3,  "R2 increment x3 (R13 load)");
    expect_reg(2, 15, "R3 decrement wraps 0->15");
    expect_reg(3, 0,  "R4 increment wraps 15->0");
    expect_reg(4, 0,  "R5 zero clears");
    expect_reg(5, 1,  "R2 single increment");
    expect_reg(6, 0,  "R6 no-op leaves register");
    expect_reg(7, 0,  "R6 unselected register untouched");
  endtask

  // R1: reset state
  task automatic t_reset();
    int v;
    hold_reset();
    check(dbg_pc == 8'd0, "R1 pc in reset", int'(dbg_pc), 0);
    read_reg(1, v); check(v == 0, "R1 register 1 cleared", v, 0);
    read_reg(2, v); check(v == 0, "R1 register 2 cleared", v, 0);
  endtask

  // R8 R10 R11: conditional jump paths
  task automatic t_cond();
    hold_reset();
    put(0, 8'h40); put(1, 8'h85); put(2, 8'h86); put(3, 8'h81);
    put(4, 8'h41); put(5, 8'h0A); put(6, 8'h87); put(7, 8'h88);
    put(8, 8'h88); put(9, 8'h88); put(10, 8'h89);
    put(11, 8'h7F); put(12, 8'h0B); put(13, 8'h00);
    release_reset();
    repeat (40) @(negedge clk);
    expect_reg(5, 0, "R10 address word not executed (not taken)");
    expect_reg(6, 1, "R11 delay slot runs when not taken");
    expect_reg(7, 1, "R11 delay slot runs when taken");
    expect_reg(8, 0, "R8 skipped words after taken jump");
    expect_reg(9, 1, "R8 target reached");
    expect_reg(0, 0, "R6 jump leaves register");
  endtask

  // R8 R9 R11: counted loop
  task automatic t_loop();
    hold_reset();
    put(0, 8'h81); put(1, 8'h81); put(2, 8'h81);
    put(3, 8'h82); put(4, 8'h91); put(5, 8'h41); put(6, 8'h03);
    put(7, 8'h83); put(8, 8'h7F); put(9, 8'h08); put(10, 8'h00);
    release_reset();
    repeat (60) @(negedge clk);
    check(dbg_pc >= 8'd8 && dbg_pc <= 8'd10, "R9 halt loop on zero register",
          int'(dbg_pc), 8);
    expect_reg(1, 0, "R8 loop counter drained");
    expect_reg(2, 3, "R8 loop body count");
    expect_reg(3, 3, "R11 delay slot count");
  endtask

  // R7 R8 R9 R12: cycle-exact counter trace
  task automatic t_trace();
    hold_reset();
    put(0, 8'h70); put(1, 8'h20); put(2, 8'h8A); put(3, 8'h8B);
    put(8'h20, 8'h7F); put(8'h21, 8'h20); put(8'h22, 8'h00);
    release_reset();
    check(dbg_pc == 8'd0, "R1 first cycle out of reset", int'(dbg_pc), 0);
    @(negedge clk); check(dbg_pc == 8'd1, "R7 step 1", int'(dbg_pc), 1);
    @(negedge clk); check(dbg_pc == 8'd2, "R7 step 2", int'(dbg_pc), 2);
    @(negedge clk); check(dbg_pc == 8'h20, "R9 forced jump load", int'(dbg_pc), 32);
    @(negedge clk); check(dbg_pc == 8'h21, "R12 pc after load", int'(dbg_pc), 33);
    repeat (20) @(negedge clk);
    expect_reg(10, 1, "R11 delay slot of forced jump");
    expect_reg(11, 0, "R9 word after delay slot skipped");
    expect_reg(0, 0, "R12 debug read register 0");
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_arith();
    t_reset();
    t_cond();
    t_loop();
    t_trace();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule